// File: doc/BRIEF.md
# Host Sector Transfer Engine

This block hands data from a 16 KB sector buffer to a host processor one 16-bit word at a time. Software first loads a byte count and a start address, picks a destination with a 3-bit code, and then issues a trigger write. For the two host-read destinations, each host read strobe returns the big-endian word at the current even buffer address. It then advances the address and decrements the count. When the signed count reaches zero or below, the transfer ends: the engine returns to idle and raises a transfer-end interrupt.

For every other destination, the engine only holds its busy status until an external completion pulse arrives, and then runs the same end sequence. The status bits are active low. The upper nibble of the byte count acts as a marker that is set at transfer end and cleared on trigger and on acknowledge.

Top module: `xfer_engine`

## Requirements
- R1: After reset the status byte reads 0xFF (with `dec_pend_n` high), the byte count and the data address are 0, and `irq`, `eot_flag` and `rdy_flag` are low. Status byte layout: bit 6 transfer-end (active low), bit 5 mirrors `dec_pend_n`, bit 3 busy (active low), bit 1 data enable (active low), and all other bits read 1.
- R2: Register selects are: 0 interface control, 1 count low byte, 2 count high byte, 3 address low byte, 4 address high byte, 5 trigger, 6 acknowledge. A trigger takes effect only when control bit 1 (output enable) is set. It then drives busy low, clears count bits 15:12, and clears `eot_flag` and `rdy_flag`. Without output enable, a trigger changes nothing.
- R3: On a trigger, destination codes 2 and 3 (host read) also drive data enable low and set `rdy_flag`. Any other code drives only busy low, so data enable stays high. Data enable is never low while busy is high.
- R4: A host read while data enable is low returns `buf_rdata`, fetched at `buf_addr` = data address with bit 0 cleared. On the next edge the data address increases by 2 and the byte count decreases by 2.
- R5: If a host read leaves a count that is ≤ 0 as a signed 16-bit value, the count becomes 0xF000. Busy and data enable return high, transfer-end goes low, `rdy_flag` clears and `eot_flag` sets.
- R6: A host read while data enable is high returns 0xFFFF and changes no count, address or status.
- R7: An acknowledge sets the transfer-end bit high and clears count bits 15:12.
- R8: Writing interface control with bit 1 clear sets the busy and data enable bits high, which aborts any transfer.
- R9: `irq` is high exactly when (control bit 6 is set and transfer-end is low) or (control bit 5 is set and `dec_pend_n` is low). A control write that makes both terms false drops it.
- R10: A pulse on `xfer_done` while busy is low and data enable is high runs the R5 end sequence and leaves the address unchanged. In any other state the pulse is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (see R2) |
| reg_wdata | input | 8 | Register write data |
| dest_code | input | 3 | Destination code sampled on trigger |
| host_rd | input | 1 | Host word read strobe |
| host_rdata | output | 16 | Word returned to the host |
| buf_addr | output | 14 | Even word address into the sector buffer |
| buf_rdata | input | 16 | Big-endian buffer word at `buf_addr` |
| xfer_done | input | 1 | Completion pulse for non-host destinations |
| dec_pend_n | input | 1 | Decoder interrupt pending, active low |
| status | output | 8 | Interface status byte |
| byte_cnt | output | 16 | Data byte counter |
| data_addr | output | 16 | Data address counter |
| irq | output | 1 | Interrupt request |
| eot_flag | output | 1 | End-of-transfer flag |
| rdy_flag | output | 1 | Host data-ready flag |

## Verification
Host transfers run with an even count that reaches exactly zero and with an odd count that goes negative. Both must end after the expected read, which tells the signed test apart from an equality test. The host transfer also starts at an odd address and with a preloaded upper nibble, which exposes a missing address mask or nibble clear. A trigger with output enable off, a read with no data enabled, and a completion pulse while idle each check that nothing moves. A non-host destination paired with the completion input, and an abort in mid-transfer, separate the two ways of returning to idle. The interrupt is driven through both its sources and both enables.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
    localparam int STAT_TE   = 6;
    localparam int STAT_DEC  = 5;
    localparam int STAT_BUSY = 3;
    localparam int STAT_DEN  = 1;

    localparam int CTL_TEIE  = 6;
    localparam int CTL_DECIE = 5;
    localparam int CTL_OUTEN = 1;

    typedef enum logic [2:0] {
        SEL_CTL    = 3'd0,
        SEL_CNT_LO = 3'd1,
        SEL_CNT_HI = 3'd2,
        SEL_ADR_LO = 3'd3,
        SEL_ADR_HI = 3'd4,
        SEL_TRIG   = 3'd5,
        SEL_ACK    = 3'd6,
        SEL_NONE   = 3'd7
    } sel_e;

    localparam logic [2:0] DST_HOST_A = 3'd2;
    localparam logic [2:0] DST_HOST_B = 3'd3;

    typedef struct packed {
        logic ctl_wr;
        logic cnt_lo_wr;
        logic cnt_hi_wr;
        logic adr_lo_wr;
        logic adr_hi_wr;
        logic trig;
        logic host_dst;
        logic ack;
        logic rd;
        logic end_x;
    } evt_t;
endpackage

// File: rtl/xfer_decode.sv
module xfer_decode
    import xfer_pkg::*;
(
    input  logic       reg_wr,
    input  logic [2:0] reg_sel,
    input  logic [2:0] dest_code,
    input  logic       host_rd,
    input  logic       xfer_done,
    input  logic       outen,
    input  logic       busy_n,
    input  logic       den_n,
    input  logic       end_hit,
    output evt_t       evt
);
    always_comb begin
        evt           = '0;
        evt.ctl_wr    = reg_wr && (reg_sel == SEL_CTL);
        evt.cnt_lo_wr = reg_wr && (reg_sel == SEL_CNT_LO);
        evt.cnt_hi_wr = reg_wr && (reg_sel == SEL_CNT_HI);
        evt.adr_lo_wr = reg_wr && (reg_sel == SEL_ADR_LO);
        evt.adr_hi_wr = reg_wr && (reg_sel == SEL_ADR_HI);
        evt.trig      = reg_wr && (reg_sel == SEL_TRIG) && outen;
        evt.ack       = reg_wr && (reg_sel == SEL_ACK);
        evt.host_dst  = (dest_code == DST_HOST_A) || (dest_code == DST_HOST_B);
        evt.rd        = host_rd && !den_n;
        // end of transfer: last host word, or completion of a non-host move
        evt.end_x     = (evt.rd && end_hit) || (xfer_done && !busy_n && den_n);
    end
endmodule

// File: rtl/xfer_counters.sv
module xfer_counters
    import xfer_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  evt_t               evt,
    input  logic [REG_W-1:0]   wdata,
    output logic [2*REG_W-1:0] cnt_q,
    output logic [2*REG_W-1:0] addr_q,
    output logic               end_hit
);
    localparam int WORD_W = 2 * REG_W;
    localparam logic [WORD_W-1:0] STEP    = WORD_W'(2);
    localparam logic [WORD_W-1:0] END_VAL = {4'hF, {(WORD_W-4){1'b0}}};

    typedef struct packed {
        logic [WORD_W-1:0] cnt;
        logic [WORD_W-1:0] addr;
    } ctr_t;

    ctr_t s_d, s_q;
    logic [WORD_W-1:0] cnt_dec;

    always_comb begin
        cnt_dec = s_q.cnt - STEP;
        end_hit = cnt_dec[WORD_W-1] || (cnt_dec == '0);
    end

    always_comb begin
        s_d = s_q;
        if (evt.rd) begin
            s_d.addr = s_q.addr + STEP;
            s_d.cnt  = cnt_dec;
        end
        if (evt.end_x)     s_d.cnt = END_VAL;
        if (evt.cnt_lo_wr) s_d.cnt[REG_W-1:0]       = wdata;
        if (evt.cnt_hi_wr) s_d.cnt[WORD_W-1:REG_W]  = wdata;
        if (evt.adr_lo_wr) s_d.addr[REG_W-1:0]      = wdata;
        if (evt.adr_hi_wr) s_d.addr[WORD_W-1:REG_W] = wdata;
        if (evt.trig || evt.ack) s_d.cnt[WORD_W-1:WORD_W-4] = 4'h0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt_q  = s_q.cnt;
    assign addr_q = s_q.addr;

    AST_CNT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (evt.end_x && !evt.trig && !evt.ack && !evt.cnt_lo_wr && !evt.cnt_hi_wr)
        |=> (s_q.cnt == END_VAL)); // R5
    AST_ACK_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        evt.ack |=> (s_q.cnt[WORD_W-1:WORD_W-4] == 4'h0)); // R7
endmodule

// File: rtl/xfer_status.sv
module xfer_status
    import xfer_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  evt_t             evt,
    input  logic [REG_W-1:0] wdata,
    input  logic             dec_pend_n,
    output logic             outen,
    output logic             busy_n,
    output logic             den_n,
    output logic [7:0]       status,
    output logic             irq,
    output logic             eot_flag,
    output logic             rdy_flag
);
    typedef struct packed {
        logic [REG_W-1:0] ctl;
        logic             te_n;
        logic             busy_n;
        logic             den_n;
        logic             eot;
        logic             rdy;
    } st_t;

    localparam st_t ST_RESET = '{ctl: '0, te_n: 1'b1, busy_n: 1'b1,
                                 den_n: 1'b1, eot: 1'b0, rdy: 1'b0};

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (evt.end_x) begin
            s_d.busy_n = 1'b1;
            s_d.den_n  = 1'b1;
            s_d.te_n   = 1'b0;
            s_d.rdy    = 1'b0;
            s_d.eot    = 1'b1;
        end
        if (evt.ctl_wr) begin
            s_d.ctl = wdata;
            if (!wdata[CTL_OUTEN]) begin
                s_d.busy_n = 1'b1;
                s_d.den_n  = 1'b1;
            end
        end
        if (evt.trig) begin
            s_d.busy_n = 1'b0;
            s_d.eot    = 1'b0;
            s_d.rdy    = 1'b0;
            if (evt.host_dst) begin
                s_d.den_n = 1'b0;
                s_d.rdy   = 1'b1;
            end
        end
        if (evt.ack) s_d.te_n = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= ST_RESET;
        else        s_q <= s_d;
    end

    always_comb begin
        status            = 8'hFF;
        status[STAT_TE]   = s_q.te_n;
        status[STAT_DEC]  = dec_pend_n;
        status[STAT_BUSY] = s_q.busy_n;
        status[STAT_DEN]  = s_q.den_n;
    end

    assign irq      = (s_q.ctl[CTL_TEIE] && !s_q.te_n) ||
                      (s_q.ctl[CTL_DECIE] && !dec_pend_n);
    assign outen    = s_q.ctl[CTL_OUTEN];
    assign busy_n   = s_q.busy_n;
    assign den_n    = s_q.den_n;
    assign eot_flag = s_q.eot;
    assign rdy_flag = s_q.rdy;

    AST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (evt.end_x && !evt.trig && !evt.ack)
        |=> (s_q.busy_n && s_q.den_n && !s_q.te_n && s_q.eot && !s_q.rdy)); // R5
    AST_DEN_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.den_n |-> !s_q.busy_n); // R3
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (evt.ctl_wr && !wdata[CTL_OUTEN]) |=> (s_q.busy_n && s_q.den_n)); // R8
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        evt.ack |=> s_q.te_n); // R7
endmodule

// File: rtl/xfer_engine.sv
module xfer_engine
    import xfer_pkg::*;
#(
    parameter int REG_W  = 8,
    parameter int BUF_AW = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [2:0]           reg_sel,
    input  logic [REG_W-1:0]     reg_wdata,
    input  logic [2:0]           dest_code,
    input  logic                 host_rd,
    output logic [2*REG_W-1:0]   host_rdata,
    output logic [BUF_AW-1:0]    buf_addr,
    input  logic [2*REG_W-1:0]   buf_rdata,
    input  logic                 xfer_done,
    input  logic                 dec_pend_n,
    output logic [7:0]           status,
    output logic [2*REG_W-1:0]   byte_cnt,
    output logic [2*REG_W-1:0]   data_addr,
    output logic                 irq,
    output logic                 eot_flag,
    output logic                 rdy_flag
);
    localparam int WORD_W = 2 * REG_W;

    evt_t evt;
    logic outen, busy_n, den_n, end_hit;

    xfer_decode i_decode (
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .dest_code (dest_code),
        .host_rd   (host_rd),
        .xfer_done (xfer_done),
        .outen     (outen),
        .busy_n    (busy_n),
        .den_n     (den_n),
        .end_hit   (end_hit),
        .evt       (evt)
    );

    xfer_counters #(.REG_W(REG_W)) i_counters (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt),
        .wdata   (reg_wdata),
        .cnt_q   (byte_cnt),
        .addr_q  (data_addr),
        .end_hit (end_hit)
    );

    xfer_status #(.REG_W(REG_W)) i_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt        (evt),
        .wdata      (reg_wdata),
        .dec_pend_n (dec_pend_n),
        .outen      (outen),
        .busy_n     (busy_n),
        .den_n      (den_n),
        .status     (status),
        .irq        (irq),
        .eot_flag   (eot_flag),
        .rdy_flag   (rdy_flag)
    );

    assign buf_addr   = {data_addr[BUF_AW-1:1], 1'b0};
    assign host_rdata = den_n ? {WORD_W{1'b1}} : buf_rdata;

    AST_IDLE_READ_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && status[STAT_DEN] && !reg_wr && !xfer_done)
        |=> ($stable(byte_cnt) && $stable(data_addr) && $stable(status))); // R6
    AST_READ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !status[STAT_DEN] && !reg_wr)
        |=> (data_addr == $past(data_addr) + WORD_W'(2))); // R4
endmodule

// File: tb/test_xfer_engine.sv
module test_xfer_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_sel = 3'd7;
    logic [7:0]  reg_wdata = 8'h00;
    logic [2:0]  dest_code = 3'd0;
    logic        host_rd = 1'b0;
    logic [15:0] host_rdata;
    logic [13:0] buf_addr;
    logic [15:0] buf_rdata;
    logic        xfer_done = 1'b0;
    logic        dec_pend_n = 1'b1;
    logic [7:0]  status;
    logic [15:0] byte_cnt, data_addr;
    logic        irq, eot_flag, rdy_flag;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    assign buf_rdata = 16'hC000 ^ {2'b00, buf_addr};

    xfer_engine i_xfer_engine (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .dest_code(dest_code), .host_rd(host_rd),
        .host_rdata(host_rdata), .buf_addr(buf_addr), .buf_rdata(buf_rdata),
        .xfer_done(xfer_done), .dec_pend_n(dec_pend_n), .status(status),
        .byte_cnt(byte_cnt), .data_addr(data_addr), .irq(irq),
        .eot_flag(eot_flag), .rdy_flag(rdy_flag)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] data);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0; reg_sel = 3'd7;
    endtask

    task automatic hread(output logic [15:0] d);
        @(negedge clk);
        host_rd = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 status", status, 8'hFF);
        chk("R1 count", byte_cnt, 16'h0000);
        chk("R1 addr", data_addr, 16'h0000);
        chk("R1 flags", {irq, eot_flag, rdy_flag}, 3'b000);
    endtask

    task automatic t_trig_disabled();
        logic [15:0] d;
        wr(3'd0, 8'h00);
        wr(3'd1, 8'h06);
        wr(3'd2, 8'hF0);
        dest_code = 3'd2;
        wr(3'd5, 8'h00);
        chk("R2 no enable status", status, 8'hFF);
        chk("R2 no enable count", byte_cnt, 16'hF006);
        hread(d);
        chk("R6 idle read data", d, 16'hFFFF);
        chk("R6 idle read addr", data_addr, 16'h0000);
        chk("R6 idle read count", byte_cnt, 16'hF006);
    endtask

    task automatic t_host_even();
        logic [15:0] d;
        wr(3'd0, 8'h42);
        wr(3'd3, 8'h35);
        wr(3'd4, 8'h12);
        dest_code = 3'd2;
        wr(3'd5, 8'h00);
        chk("R2 trigger count nibble", byte_cnt, 16'h0006);
        chk("R3 host status", status, 8'hF5);
        chk("R3 ready", {eot_flag, rdy_flag}, 2'b01);
        hread(d);
        chk("R4 word0", d, 16'hD234);
        chk("R4 addr step", data_addr, 16'h1237);
        chk("R4 count step", byte_cnt, 16'h0004);
        hread(d);
        chk("R4 word1", d, 16'hD236);
        chk("R5 not yet ended", status, 8'hF5);
        hread(d);
        chk("R4 word2", d, 16'hD238);
        chk("R5 end count", byte_cnt, 16'hF000);
        chk("R5 end status", status, 8'hBF);
        chk("R5 end flags", {eot_flag, rdy_flag}, 2'b10);
        chk("R9 irq on end", irq, 1'b1);
        chk("R4 final addr", data_addr, 16'h123B);
    endtask

    task automatic t_ack();
        wr(3'd6, 8'h00);
        chk("R7 ack status", status, 8'hFF);
        chk("R7 ack count", byte_cnt, 16'h0000);
        chk("R9 irq drops", irq, 1'b0);
    endtask

    task automatic t_host_odd();
        logic [15:0] d;
        wr(3'd1, 8'h03);
        wr(3'd2, 8'h00);
        dest_code = 3'd3;
        wr(3'd5, 8'h00);
        chk("R3 dest3 status", status, 8'hF5);
        hread(d);
        chk("R5 odd mid count", byte_cnt, 16'h0001);
        chk("R5 odd mid status", status, 8'hF5);
        hread(d);
        chk("R5 odd negative end", byte_cnt, 16'hF000);
        chk("R5 odd end status", status, 8'hBF);
        wr(3'd6, 8'h00);
    endtask

    task automatic t_abort();
        logic [15:0] d;
        wr(3'd1, 8'h20);
        dest_code = 3'd2;
        wr(3'd5, 8'h00);
        chk("R3 abort setup", status, 8'hF5);
        wr(3'd0, 8'h40);
        chk("R8 abort status", status, 8'hFF);
        hread(d);
        chk("R8 read after abort", d, 16'hFFFF);
        chk("R8 count held", byte_cnt, 16'h0020);
    endtask

    task automatic t_nonhost();
        logic [15:0] d;
        wr(3'd0, 8'h02);
        dest_code = 3'd5;
        wr(3'd5, 8'h00);
        chk("R3 nonhost status", status, 8'hF7);
        chk("R3 nonhost ready", rdy_flag, 1'b0);
        hread(d);
        chk("R6 nonhost read", d, 16'hFFFF);
        pulse_done();
        chk("R10 done status", status, 8'hBF);
        chk("R10 done count", byte_cnt, 16'hF000);
        chk("R10 done eot", eot_flag, 1'b1);
        chk("R9 no irq without enable", irq, 1'b0);
        wr(3'd0, 8'h42);
        chk("R9 irq on enable", irq, 1'b1);
        wr(3'd6, 8'h00);
        chk("R9 irq after ack", irq, 1'b0);
        pulse_done();
        chk("R10 idle done ignored", status, 8'hFF);
        chk("R10 idle done count", byte_cnt, 16'h0000);
    endtask

    task automatic t_dec_irq();
        dec_pend_n = 1'b0;
        wr(3'd0, 8'h02);
        chk("R9 dec masked", irq, 1'b0);
        chk("R1 dec bit", status, 8'hDF);
        wr(3'd0, 8'h22);
        chk("R9 dec irq", irq, 1'b1);
        wr(3'd0, 8'h02);
        chk("R9 dec dropped", irq, 1'b0);
        dec_pend_n = 1'b1;
    endtask

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_trig_disabled();
        t_host_even();
        t_ack();
        t_host_odd();
        t_abort();
        t_nonhost();
        t_dec_irq();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule